// File: doc/BRIEF.md
# External Bus Sequencer with Deferred Bus Release

This block sits between a processor's internal memory requests and its external bus. Each internal request is a byte, word or longword access, optionally marked as locked. The block turns each request into one logical bus cycle of narrow external accesses. The width of the region, selected by one address bit, sets how many accesses are needed. A locked request becomes a read pass followed by a write pass to the same bytes, and the whole sequence counts as one indivisible cycle.

Another master may ask for the bus through an active-low request pin. The block synchronises that pin and finishes whatever logical cycle is in flight. It then floats its address, data and strobe drivers and only after that acknowledges. While the bus is away, new internal requests see `req_ready` low and wait. When the request pin is withdrawn, the acknowledge is removed first and the drivers come back one cycle later. Held requests are then served in their original order.

Top module: `xbus_sequencer`

## Requirements
- R1: During and right after reset, the block owns the bus. `ext_back_n`, `ext_rd_n` and `ext_wr_n` are high, `ext_drive_en` and `req_ready` are high, and `ext_data_en` and `rsp_valid` are low.
- R2: The region is 8 bits wide when `req_addr[NARROW_BIT]` is 1, and 16 bits wide otherwise. `req_size` 0/1/2 means byte/word/longword. An 8-bit region uses 1/2/4 external accesses. A 16-bit region uses 1 access for a byte or word and 2 for a longword. Every access keeps its strobe low for exactly 2 clock cycles, with no gap between the accesses of one request.
- R3: Access i goes to base + i for an 8-bit region and to base + 2i for a 16-bit region, and the most significant part goes first. Lane enables `ext_be` are {upper = D15:8, lower = D7:0}. An 8-bit region always uses 2'b01. A 16-bit byte access uses 2'b10 at an even address and 2'b01 at an odd address. A 16-bit word or longword uses 2'b11.
- R4: Read data is packed right-justified into `rsp_rdata` in big-endian byte order. `rsp_valid` is high for exactly one cycle, in the cycle after the final access.
- R5: When `req_lock` is set, all read accesses are made first, then all write accesses to the same addresses with `req_wdata`. The response carries the value that was read, and the bus is not released between the two passes.
- R6: The bus is released only after every access of the current logical cycle has finished. No strobe is active while the drivers are off.
- R7: `ext_breq_n` passes through two flip-flops. If it is low before edge 0 while the block is idle, the drivers turn off after edge 2 and `ext_back_n` goes low after edge 3.
- R8: If `ext_breq_n` returns high before edge 0, `ext_back_n` goes high after edge 2 and the drivers turn back on after edge 3.
- R9: While the bus is away, `req_ready` is low and a held request makes no access. The request is served once the bus is back.
- R10: In an idle cycle in which the synchronised bus request is already present, `req_ready` is low, so release is chosen over a waiting internal request.
- R11: `ext_data_en` is high only during write accesses, and only while the block owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read (ignored when locked) |
| req_lock | input | 1 | Locked read-then-write |
| req_size | input | 2 | 0 byte, 1 word, 2 longword |
| req_addr | input | AW | Aligned start address |
| req_wdata | input | 32 | Right-justified write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Right-justified read data |
| ext_addr | output | AW | External address |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_be | output | 2 | Byte lane enables {D15:8, D7:0} |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| ext_drive_en | output | 1 | Enable for address, strobe and lane drivers |
| ext_data_en | output | 1 | Enable for data drivers |
| ext_breq_n | input | 1 | Bus request from another master, active low |
| ext_back_n | output | 1 | Bus acknowledge, active low |

## Verification
Several properties are checked on every cycle:
- no strobe while the drivers are off;
- `req_ready` is low while the bus is away;
- the arbiter leaves ownership only when the access engine is idle;
- the drivers are off before the acknowledge falls, and the acknowledge is high before they return;
- the data enable is on only during writes;
- a response follows directly after an access and lasts one cycle.

Other behaviour can only be shown by the bench's scenarios:
- the exact access counts, addresses, lane enables and big-endian packing for every size, region width and mode;
- the read-then-write order of locked requests;
- the cycle-exact latency of the synchroniser and handshake;
- the release being deferred until a longword or locked sequence already in progress has ended.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int PORT_W = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        ARB_OWN     = 2'd0,
        ARB_FLOAT   = 2'd1,
        ARB_HANDED  = 2'd2,
        ARB_RECLAIM = 2'd3
    } arb_state_e;

    // Engine sequencing state for one logical cycle.
    typedef struct packed {
        logic       busy;
        logic       t2;
        logic       writing;
        logic       lock_pend;
        logic [1:0] beat;
        logic [1:0] last;
    } seq_state_t;

    // Index of the final access of a request.
    function automatic logic [1:0] last_beat(input logic [1:0] size, input logic narrow);
        if (narrow) begin
            case (size)
                SZ_BYTE: return 2'd0;
                SZ_WORD: return 2'd1;
                default: return 2'd3;
            endcase
        end
        return (size == SZ_BYTE || size == SZ_WORD) ? 2'd0 : 2'd1;
    endfunction

    // Byte offset of access 'beat' from the base address.
    function automatic logic [2:0] beat_offset(input logic [1:0] beat, input logic narrow);
        return narrow ? {1'b0, beat} : {beat, 1'b0};
    endfunction

    // Data placed on the port for access with 'rem' accesses still to follow.
    function automatic logic [PORT_W-1:0] lane_data(input logic [WORD_W-1:0] wd,
                                                   input logic [1:0] size,
                                                   input logic narrow,
                                                   input logic [1:0] rem);
        logic [WORD_W-1:0] sh;
        logic [7:0]        b;
        sh = wd >> (8 * rem);
        b  = narrow ? sh[7:0] : wd[7:0];
        if (narrow || size == SZ_BYTE) return {b, b};
        if (size == SZ_LONG && rem == 2'd1) return wd[31:16];
        return wd[15:0];
    endfunction

    // Lane enables {upper, lower}.
    function automatic logic [1:0] lane_enable(input logic narrow, input logic [1:0] size,
                                               input logic a0);
        if (narrow) return 2'b01;
        if (size == SZ_BYTE) return a0 ? 2'b01 : 2'b10;
        return 2'b11;
    endfunction

    // Fold one access's read data into the accumulator, big-endian.
    function automatic logic [WORD_W-1:0] merge_read(input logic [WORD_W-1:0] acc,
                                                    input logic [PORT_W-1:0] din,
                                                    input logic narrow,
                                                    input logic [1:0] size,
                                                    input logic a0);
        if (narrow) return {acc[23:0], din[7:0]};
        if (size == SZ_BYTE) return {24'h0, (a0 ? din[7:0] : din[15:8])};
        return {acc[15:0], din};
    endfunction

endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic req_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], async_n};
    end

    assign req_o = ~chain[STAGES-1];
endmodule

// File: rtl/xbus_arbiter.sv
module xbus_arbiter
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       breq_s,
    input  logic       eng_idle,
    output arb_state_e state_o,
    output logic       own_o,
    output logic       back_n_o
);
    arb_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ARB_OWN:     if (breq_s && eng_idle) nxt = ARB_FLOAT;
            ARB_FLOAT:   nxt = ARB_HANDED;
            ARB_HANDED:  if (!breq_s) nxt = ARB_RECLAIM;
            ARB_RECLAIM: nxt = ARB_OWN;
            default:     nxt = ARB_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ARB_OWN;
        else     state <= nxt;
    end

    assign state_o  = state;
    assign own_o    = (state == ARB_OWN);
    assign back_n_o = (state != ARB_HANDED);

    // R7
    handed_via_float_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ARB_HANDED) |-> $past(state) == ARB_FLOAT);
endmodule

// File: rtl/xbus_engine.sv
module xbus_engine
    import xbus_pkg::*;
#(
    parameter int AW         = 16,
    parameter int NARROW_BIT = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              grant_ok,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_lock,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              idle_o,
    input  logic [PORT_W-1:0] ext_din,
    output logic              strb_rd,
    output logic              strb_wr,
    output logic [AW-1:0]     beat_addr,
    output logic [PORT_W-1:0] beat_data,
    output logic [1:0]        beat_be,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata
);
    seq_state_t        st;
    logic [1:0]        size_q;
    logic              narrow_q;
    logic [AW-1:0]     base_q;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] merged;
    logic              accept;

    assign req_ready = !st.busy && grant_ok;
    assign accept    = req_valid && req_ready;
    assign idle_o    = !st.busy;

    assign beat_addr = base_q + AW'(beat_offset(st.beat, narrow_q));
    assign beat_data = lane_data(wdata_q, size_q, narrow_q, st.last - st.beat);
    assign beat_be   = st.busy ? lane_enable(narrow_q, size_q, beat_addr[0]) : 2'b00;
    assign merged    = merge_read(acc, ext_din, narrow_q, size_q, beat_addr[0]);
    assign strb_rd   = st.busy && !st.writing;
    assign strb_wr   = st.busy && st.writing;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            size_q    <= '0;
            narrow_q  <= 1'b0;
            base_q    <= '0;
            wdata_q   <= '0;
            acc       <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (accept) begin
                st.busy      <= 1'b1;
                st.t2        <= 1'b0;
                st.beat      <= 2'd0;
                st.last      <= last_beat(req_size, req_addr[NARROW_BIT]);
                st.writing   <= req_write && !req_lock;
                st.lock_pend <= req_lock;
                size_q       <= req_size;
                narrow_q     <= req_addr[NARROW_BIT];
                base_q       <= req_addr;
                wdata_q      <= req_wdata;
                acc          <= '0;
            end else if (st.busy) begin
                if (!st.t2) begin
                    st.t2 <= 1'b1;
                end else begin
                    st.t2 <= 1'b0;
                    if (!st.writing) acc <= merged;
                    if (st.beat != st.last) begin
                        st.beat <= st.beat + 2'd1;
                    end else if (st.lock_pend) begin
                        st.lock_pend <= 1'b0;
                        st.writing   <= 1'b1;
                        st.beat      <= 2'd0;
                    end else begin
                        st.busy   <= 1'b0;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= st.writing ? acc : merged;
                    end
                end
            end
        end
    end

    // R4
    rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R5
    lock_order_chk: assert property (@(posedge clk) disable iff (rst)
        (st.busy && $past(st.busy) && $past(st.writing)) |-> st.writing);
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int NARROW_BIT  = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_lock,
    input  logic [1:0]        req_size,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [AW-1:0]     ext_addr,
    output logic [15:0]       ext_dout,
    input  logic [15:0]       ext_din,
    output logic [1:0]        ext_be,
    output logic              ext_rd_n,
    output logic              ext_wr_n,
    output logic              ext_drive_en,
    output logic              ext_data_en,
    input  logic              ext_breq_n,
    output logic              ext_back_n
);
    logic       breq_s;
    logic       eng_idle;
    logic       own;
    logic       strb_rd;
    logic       strb_wr;
    arb_state_e arb_state;

    xbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (ext_breq_n),
        .req_o   (breq_s)
    );

    xbus_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .breq_s   (breq_s),
        .eng_idle (eng_idle),
        .state_o  (arb_state),
        .own_o    (own),
        .back_n_o (ext_back_n)
    );

    xbus_engine #(.AW(AW), .NARROW_BIT(NARROW_BIT)) u_eng (
        .clk       (clk),
        .rst       (rst),
        .grant_ok  (own && !breq_s),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_lock  (req_lock),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .idle_o    (eng_idle),
        .ext_din   (ext_din),
        .strb_rd   (strb_rd),
        .strb_wr   (strb_wr),
        .beat_addr (ext_addr),
        .beat_data (ext_dout),
        .beat_be   (ext_be),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign ext_rd_n     = !strb_rd;
    assign ext_wr_n     = !strb_wr;
    assign ext_drive_en = own;
    assign ext_data_en  = own && strb_wr;

    // R6
    release_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (arb_state == ARB_FLOAT) |-> eng_idle);

    // R6
    no_strobe_released_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_drive_en |-> (ext_rd_n && ext_wr_n));

    // R9
    stall_released_chk: assert property (@(posedge clk) disable iff (rst)
        !ext_drive_en |-> !req_ready);

    // R7
    float_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_back_n) |-> $past(!ext_drive_en));

    // R8
    ack_off_before_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_drive_en) |-> $past(ext_back_n));

    // R11
    data_en_write_chk: assert property (@(posedge clk) disable iff (rst)
        ext_data_en |-> (!ext_wr_n && ext_drive_en));

    // R4
    rsp_after_access_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(!ext_rd_n || !ext_wr_n));
endmodule

// File: tb/sim_xbus_sequencer.sv
`timescale 1ns/1ps
module sim_xbus_sequencer;
    localparam int AW = 16;
    localparam int NB = 15;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst;
    logic          req_valid, req_ready, req_write, req_lock;
    logic [1:0]    req_size;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_wdata;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic [AW-1:0] ext_addr;
    logic [15:0]   ext_dout, ext_din;
    logic [1:0]    ext_be;
    logic          ext_rd_n, ext_wr_n, ext_drive_en, ext_data_en;
    logic          ext_breq_n, ext_back_n;

    xbus_sequencer #(.AW(AW), .NARROW_BIT(NB)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_lock(req_lock), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din),
        .ext_be(ext_be), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
        .ext_drive_en(ext_drive_en), .ext_data_en(ext_data_en),
        .ext_breq_n(ext_breq_n), .ext_back_n(ext_back_n)
    );

    // External memory model: 8-bit region on D7:0, 16-bit region big-endian.
    logic [7:0] mem [0:255];
    logic [7:0] idx;
    assign idx = ext_addr[7:0];
    always_comb begin
        if (ext_addr[NB]) ext_din = {8'h00, mem[idx]};
        else              ext_din = {mem[{idx[7:1], 1'b0}], mem[{idx[7:1], 1'b1}]};
    end

    int nchk = 0;
    int nfail = 0;
    int stb_cnt = 0;
    int den_cnt = 0;
    int rsp_cnt = 0;
    int overlap = 0;
    logic [31:0]   last_rsp;
    logic [AW-1:0] tr_addr [0:63];
    logic [1:0]    tr_be   [0:63];

    always @(negedge clk) begin
        if (!rst) begin
            if (!ext_rd_n || !ext_wr_n) begin
                if (stb_cnt % 2 == 0) begin
                    tr_addr[(stb_cnt / 2) % 64] = ext_addr;
                    tr_be[(stb_cnt / 2) % 64]   = ext_be;
                end
                stb_cnt++;
                if (!ext_back_n || !ext_drive_en) overlap++;
            end
            if (ext_data_en) begin
                den_cnt++;
                if (ext_addr[NB]) begin
                    if (ext_be[0]) mem[idx] = ext_dout[7:0];
                end else begin
                    if (ext_be[1]) mem[{idx[7:1], 1'b0}] = ext_dout[15:8];
                    if (ext_be[0]) mem[{idx[7:1], 1'b1}] = ext_dout[7:0];
                end
            end
            if (rsp_valid) begin
                rsp_cnt++;
                last_rsp = rsp_rdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start_req(input logic [AW-1:0] a, input logic [1:0] sz,
                             input logic wr, input logic lk, input logic [31:0] wd);
        req_addr  = a;
        req_size  = sz;
        req_write = wr;
        req_lock  = lk;
        req_wdata = wd;
        req_valid = 1'b1;
    endtask

    // Wait for acceptance and then for the response.
    task automatic wait_done(input int r0);
        for (int g = 0; g < 100 && !req_ready; g++) step();
        step();
        req_valid = 1'b0;
        for (int g = 0; g < 40 && rsp_cnt == r0; g++) step();
        step();
    endtask

    function automatic int nbeats(input logic narrow, input logic [1:0] sz);
        if (narrow) return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        return (sz == 2'd2) ? 2 : 1;
    endfunction

    logic done = 1'b0;

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        rst = 1'b1; ext_breq_n = 1'b1; req_valid = 1'b0; req_write = 1'b0;
        req_lock = 1'b0; req_size = 2'd0; req_addr = '0; req_wdata = '0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1 back_n", 32'(ext_back_n), 32'd1);
        chk("R1 rd_n", 32'(ext_rd_n), 32'd1);
        chk("R1 wr_n", 32'(ext_wr_n), 32'd1);
        chk("R1 drive_en", 32'(ext_drive_en), 32'd1);
        chk("R1 data_en", 32'(ext_data_en), 32'd0);
        chk("R1 req_ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);

        // Sweep: region width x size x mode (0 read, 1 write, 2 locked)
        for (int nw = 0; nw < 2; nw++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int md = 0; md < 3; md++) begin
                    int k, nb, nbytes, s0, d0, r0, step_b;
                    logic [AW-1:0] base;
                    logic [31:0] wd, exp_rd;
                    logic [1:0] exp_be;
                    k = nw * 9 + sz * 3 + md;
                    nb = nbeats(nw[0], sz[1:0]);
                    nbytes = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
                    base = AW'(16 + 8 * k + ((sz == 0) ? 1 : 0));
                    if (nw == 1) base[NB] = 1'b1;
                    wd = 32'hC3A59617 ^ (32'(k) * 32'h01030507);
                    exp_rd = 32'h0;
                    for (int j = 0; j < nbytes; j++)
                        exp_rd = (exp_rd << 8) | 32'(mem[8'(base + AW'(j))]);
                    s0 = stb_cnt; d0 = den_cnt; r0 = rsp_cnt;
                    start_req(base, sz[1:0], md == 1, md == 2, wd);
                    wait_done(r0);
                    // R2 access count and length
                    chk($sformatf("R2 strobe cycles nw=%0d sz=%0d md=%0d", nw, sz, md),
                        32'(stb_cnt - s0), 32'(2 * nb * ((md == 2) ? 2 : 1)));
                    // R11 data enable only on writes
                    chk($sformatf("R11 data_en cycles nw=%0d sz=%0d md=%0d", nw, sz, md),
                        32'(den_cnt - d0), 32'((md == 0) ? 0 : 2 * nb));
                    // R4 one response pulse
                    chk($sformatf("R4 rsp count nw=%0d sz=%0d md=%0d", nw, sz, md),
                        32'(rsp_cnt - r0), 32'd1);
                    // R3 addresses and lanes
                    step_b = (nw == 1) ? 1 : 2;
                    exp_be = (nw == 1) ? 2'b01 : (sz == 0) ? (base[0] ? 2'b01 : 2'b10) : 2'b11;
                    for (int i = 0; i < nb; i++) begin
                        chk($sformatf("R3 addr beat%0d nw=%0d sz=%0d md=%0d", i, nw, sz, md),
                            32'(tr_addr[((s0 / 2) + i) % 64]), 32'(base + AW'(i * step_b)));
                        chk($sformatf("R3 be beat%0d nw=%0d sz=%0d md=%0d", i, nw, sz, md),
                            32'(tr_be[((s0 / 2) + i) % 64]), 32'(exp_be));
                    end
                    if (md != 1)
                        chk($sformatf("R4 R5 read data nw=%0d sz=%0d md=%0d", nw, sz, md),
                            last_rsp, exp_rd);
                    if (md != 0)
                        for (int j = 0; j < nbytes; j++)
                            chk($sformatf("R3 R5 mem byte%0d nw=%0d sz=%0d md=%0d", j, nw, sz, md),
                                32'(mem[8'(base + AW'(j))]), 32'(8'(wd >> (8 * (nbytes - 1 - j)))));
                end
            end
        end

        // R7 idle release timing
        ext_breq_n = 1'b0;
        step(); chk("R7 drive after e0", 32'(ext_drive_en), 32'd1);
        step(); chk("R7 drive after e1", 32'(ext_drive_en), 32'd1);
        step(); chk("R7 drive off after e2", 32'(ext_drive_en), 32'd0);
        chk("R7 back_n high after e2", 32'(ext_back_n), 32'd1);
        step(); chk("R7 back_n low after e3", 32'(ext_back_n), 32'd0);

        // R9 request held while released
        begin
            int s0, r0;
            logic [31:0] exp_rd;
            s0 = stb_cnt; r0 = rsp_cnt;
            exp_rd = {mem[8'h30], mem[8'h31], mem[8'h32], mem[8'h33]};
            start_req(16'h0030, 2'd2, 1'b0, 1'b0, 32'h0);
            chk("R9 ready low while released", 32'(req_ready), 32'd0);
            repeat (5) step();
            chk("R9 no access while released", 32'(stb_cnt - s0), 32'd0);
            ext_breq_n = 1'b1;
            step(); chk("R8 back_n after e0", 32'(ext_back_n), 32'd0);
            step(); chk("R8 back_n after e1", 32'(ext_back_n), 32'd0);
            step(); chk("R8 back_n high after e2", 32'(ext_back_n), 32'd1);
            chk("R8 drive still off after e2", 32'(ext_drive_en), 32'd0);
            step(); chk("R8 drive on after e3", 32'(ext_drive_en), 32'd1);
            wait_done(r0);
            chk("R9 held request served", last_rsp, exp_rd);
            chk("R9 held request accesses", 32'(stb_cnt - s0), 32'd4);
        end

        // R6 request during a longword to the 8-bit region
        begin
            int s0, lat;
            start_req(16'h8040, 2'd2, 1'b0, 1'b0, 32'h0);
            step();
            req_valid = 1'b0;
            s0 = stb_cnt;
            step(); step();
            ext_breq_n = 1'b0;
            lat = 0;
            for (int g = 0; g < 40 && ext_back_n; g++) begin step(); lat++; end
            chk("R6 whole cycle before release", 32'(stb_cnt - s0), 32'd8);
            chk("R6 release latency", 32'(lat), 32'd8);
            chk("R6 no strobe while released", 32'(overlap), 32'd0);
            ext_breq_n = 1'b1;
            repeat (5) step();
        end

        // R5 request during locked read half
        begin
            int s0;
            logic [31:0] exp_rd;
            exp_rd = {mem[8'h50], mem[8'h51], mem[8'h52], mem[8'h53]};
            s0 = stb_cnt;
            start_req(16'h8050, 2'd2, 1'b0, 1'b1, 32'h1234ABCD);
            step();
            req_valid = 1'b0;
            step();
            ext_breq_n = 1'b0;
            for (int g = 0; g < 60 && ext_back_n; g++) step();
            chk("R5 both halves before release", 32'(stb_cnt - s0), 32'd16);
            chk("R5 locked read value", last_rsp, exp_rd);
            chk("R5 locked write value", {mem[8'h50], mem[8'h51], mem[8'h52], mem[8'h53]},
                32'h1234ABCD);
            ext_breq_n = 1'b1;
            repeat (5) step();
        end

        // R10 release wins in an idle cycle
        begin
            int s0, r0;
            logic [31:0] exp_rd;
            ext_breq_n = 1'b0;
            step(); step();
            s0 = stb_cnt; r0 = rsp_cnt;
            exp_rd = {24'h0, mem[8'h60]};
            start_req(16'h0060, 2'd0, 1'b0, 1'b0, 32'h0);
            chk("R10 ready low with pending bus request", 32'(req_ready), 32'd0);
            step();
            chk("R10 drivers off instead of access", 32'(ext_drive_en), 32'd0);
            chk("R10 no strobe", 32'(stb_cnt - s0), 32'd0);
            for (int g = 0; g < 10 && ext_back_n; g++) step();
            ext_breq_n = 1'b1;
            wait_done(r0);
            chk("R10 request served after return", last_rsp, exp_rd);
        end

        chk("R6 R11 overlap total", 32'(overlap), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule